// File: doc/BRIEF.md
# Single-Frame Word-Port Buffer for an Ethernet MAC

This block sits on a processor's register bus in front of a simple byte-stream MAC. Each direction holds at most one frame at a time. To transmit, software fills a transmit buffer one 32-bit word per register write. It then starts the transfer by writing the byte count and a start bit to the transmit control register. The block streams the frame out byte by byte over a valid/ready handshake. It clears the busy bit when the final byte has been taken, and the error bit reports the line's failure indication.

On the receive side, the block collects one incoming frame into its buffer and reports ready, error and length in the receive control register. Software pops the frame one word per read of the receive data port and releases the buffer by writing zero. Frames that arrive while a frame is still held are dropped and counted. One interrupt line serves both causes. The receive cause is a level that follows the ready flag. The transmit-done cause is a single-cycle pulse that is lost if its enable is off at that moment.

Top module: `mac_word_port`

## Requirements
- R1: Register word addresses are 0 transmit data, 1 transmit control, 2 receive data, 3 receive control, 4 interrupt enable, 5 drop counter. Writes to address 0 while idle store words in order from index 0, where index 0 is the first write after the latest write to address 1.
- R2: Writing address 1 while idle with bit 31 set and a nonzero byte count N in bits [15:0] sets busy. Exactly N bytes then leave on the line. Byte k of the frame is taken from bits [8*(k%4)+7 : 8*(k%4)] of stored word k/4, and the last-byte flag marks only byte N-1.
- R3: Busy (bit 31 of address 1) clears once the final byte is accepted. Error (bit 30) then equals the line failure input as sampled with that final byte, and bits [15:0] read back N.
- R4: A write of zero to address 1 while idle clears the error and overrun bits and leaves the length field unchanged.
- R5: A write to address 0 while busy neither stores data nor changes the frame being sent. It sets the sticky overrun bit (bit 29 of address 1).
- R6: After a frame is received, address 3 shows ready in bit 31, the line error flag in bit 30 and the CRC error flag in bit 29, both sampled with the last byte, and the byte count in bits [15:0].
- R7: Each read of address 2 returns the next word of the held frame, with byte k in bits [8*(k%4)+7 : 8*(k%4)] of word k/4. Lanes past the frame end read as zero.
- R8: A write of zero to address 3 clears ready and all receive status, rewinds the read pointer and lets the next frame be accepted.
- R9: A frame that starts while another is held is dropped whole. The held frame's status and data are unchanged, and address 5 increments once per dropped frame.
- R10: The interrupt is high one cycle after both the held-frame flag and enable bit 0 of address 4 are set, and it falls one cycle after either clears.
- R11: When busy falls, the interrupt pulses high for exactly one cycle if enable bit 1 of address 4 is set at that moment. Otherwise no pulse is issued.
- R12: A read strobe at one clock edge gives valid read data and the read-valid flag two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_ren | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Combined interrupt |
| tx_byte | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Line accepts byte |
| tx_fail | input | 1 | Line reports failed send, sampled with final byte |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_last | input | 1 | Final incoming byte |
| rx_err | input | 1 | Receive error, sampled with final byte |
| rx_crc_err | input | 1 | CRC error, sampled with final byte |

## Verification
Transmit frames are tried at lengths 1, 4 and 5, plus random lengths up to 64, under a line ready signal that stalls at random. The fixed lengths separate full-word from partial-word endings, and the stalls check that a byte holds until it is accepted. Receive frames of lengths 1, 4 and 7 plus random lengths, with random gaps between bytes and random error flags, test both the lane packing and the zero fill of a partial last word. A second frame sent while one is held shows whether the drop leaves the held data intact. A data write during a stalled transmission shows whether an overrun corrupts the frame in flight. Runs with the transmit enable on and then off show whether the done pulse is issued only when enabled.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  localparam logic [2:0] A_TXD = 3'd0;
  localparam logic [2:0] A_TXC = 3'd1;
  localparam logic [2:0] A_RXD = 3'd2;
  localparam logic [2:0] A_RXC = 3'd3;
  localparam logic [2:0] A_IEN = 3'd4;
  localparam logic [2:0] A_OVF = 3'd5;

  localparam int B_BUSY = 31;
  localparam int B_TERR = 30;
  localparam int B_OVR  = 29;
  localparam int B_RDY  = 31;
  localparam int B_RERR = 30;
  localparam int B_CRC  = 29;
  localparam int IE_RX  = 0;
  localparam int IE_TX  = 1;

  typedef enum logic [1:0] {TX_IDLE, TX_FETCH, TX_LOAD, TX_SEND} tx_state_e;

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] l);
    case (l)
      2'd0:    return w[7:0];
      2'd1:    return w[15:8];
      2'd2:    return w[23:16];
      default: return w[31:24];
    endcase
  endfunction
endpackage

// File: rtl/mwp_tx_engine.sv
module mwp_tx_engine
  import mwp_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_data,
  input  logic             wr_ctrl,
  input  logic [31:0]      wdata,
  input  logic             line_ready,
  input  logic             line_fail,
  output logic [7:0]       line_byte,
  output logic             line_valid,
  output logic             line_last,
  output logic             busy,
  output logic             err,
  output logic             ovr,
  output logic [LEN_W-1:0] len,
  output logic             done_p
);
  localparam int AW = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [31:0]      rdq;
  logic [31:0]      word_q;
  logic [AW-1:0]    wptr;
  logic [AW-1:0]    raddr;
  logic [LEN_W-1:0] bcnt;
  logic [LEN_W-1:0] bnxt;
  logic             mem_we;
  logic             start_ok;
  logic             clear_ok;
  tx_state_e        st;

  assign mem_we   = wr_data && !busy;
  assign raddr    = bcnt[AW+1:2];
  assign bnxt     = bcnt + 1'b1;
  assign start_ok = wr_ctrl && !busy && wdata[B_BUSY] && (wdata[LEN_W-1:0] != '0);
  assign clear_ok = wr_ctrl && !busy && (wdata == '0);

  // buffer: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (mem_we) mem[wptr] <= wdata;
    rdq <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TX_IDLE;
      busy       <= 1'b0;
      err        <= 1'b0;
      ovr        <= 1'b0;
      len        <= '0;
      wptr       <= '0;
      bcnt       <= '0;
      word_q     <= '0;
      line_byte  <= '0;
      line_valid <= 1'b0;
      line_last  <= 1'b0;
      done_p     <= 1'b0;
    end else begin
      done_p <= 1'b0;
      if (wr_data) begin
        if (busy) ovr <= 1'b1;
        else      wptr <= wptr + 1'b1;
      end
      if (wr_ctrl && !busy) wptr <= '0;
      if (clear_ok) begin
        err <= 1'b0;
        ovr <= 1'b0;
      end
      if (start_ok) begin
        busy <= 1'b1;
        err  <= 1'b0;
        len  <= wdata[LEN_W-1:0];
        bcnt <= '0;
        st   <= TX_FETCH;
      end
      case (st)
        TX_FETCH: st <= TX_LOAD;
        TX_LOAD: begin
          word_q     <= rdq;
          line_byte  <= rdq[7:0];
          line_valid <= 1'b1;
          line_last  <= (bcnt == len - 1'b1);
          st         <= TX_SEND;
        end
        TX_SEND: begin
          if (line_ready) begin
            if (line_last) begin
              line_valid <= 1'b0;
              line_last  <= 1'b0;
              busy       <= 1'b0;
              err        <= line_fail;
              done_p     <= 1'b1;
              st         <= TX_IDLE;
            end else begin
              bcnt <= bnxt;
              if (bcnt[1:0] == 2'd3) begin
                line_valid <= 1'b0;
                st         <= TX_FETCH;
              end else begin
                line_byte <= lane_byte(word_q, bnxt[1:0]);
                line_last <= (bnxt == len - 1'b1);
              end
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mwp_rx_engine.sv
module mwp_rx_engine
  import mwp_pkg::*;
#(
  parameter int WORDS = 512,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             in_err,
  input  logic             in_crc,
  input  logic             pop,
  input  logic             free_buf,
  output logic             ready,
  output logic             ferr,
  output logic             fcrc,
  output logic [LEN_W-1:0] flen,
  output logic [CNT_W-1:0] ovf_cnt,
  output logic [31:0]      rd_word
);
  localparam int AW = $clog2(WORDS);

  logic [31:0]      mem [WORDS];
  logic [31:0]      asm_q;
  logic [31:0]      asm_n;
  logic [LEN_W-1:0] bcnt;
  logic [AW-1:0]    rptr;
  logic [AW-1:0]    waddr;
  logic [1:0]       lane;
  logic             in_frame;
  logic             dropping;
  logic             drop_now;
  logic             we;

  assign lane     = bcnt[1:0];
  assign asm_n    = asm_q | ({24'd0, in_byte} << {lane, 3'b000});
  assign drop_now = in_frame ? dropping : ready;
  assign we       = in_valid && !drop_now && ((lane == 2'd3) || in_last);
  assign waddr    = bcnt[AW+1:2];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= asm_n;
    rd_word <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b0;
      ferr     <= 1'b0;
      fcrc     <= 1'b0;
      flen     <= '0;
      ovf_cnt  <= '0;
      asm_q    <= '0;
      bcnt     <= '0;
      rptr     <= '0;
      in_frame <= 1'b0;
      dropping <= 1'b0;
    end else begin
      if (in_valid) begin
        in_frame <= !in_last;
        if (drop_now) begin
          dropping <= !in_last;
          if (in_last) ovf_cnt <= ovf_cnt + 1'b1;
        end else begin
          dropping <= 1'b0;
          asm_q    <= ((lane == 2'd3) || in_last) ? 32'd0 : asm_n;
          bcnt     <= in_last ? '0 : bcnt + 1'b1;
          if (in_last) begin
            ready <= 1'b1;
            flen  <= bcnt + 1'b1;
            ferr  <= in_err;
            fcrc  <= in_crc;
          end
        end
      end
      if (pop) rptr <= rptr + 1'b1;
      if (free_buf) begin
        ready <= 1'b0;
        ferr  <= 1'b0;
        fcrc  <= 1'b0;
        flen  <= '0;
        rptr  <= '0;
      end
    end
  end
endmodule

// File: rtl/mac_word_port.sv
module mac_word_port
  import mwp_pkg::*;
#(
  parameter int BUF_WORDS = 512,
  parameter int LEN_W     = 16,
  parameter int OVF_W     = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wen,
  input  logic        reg_ren,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        irq,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic        tx_fail,
  input  logic [7:0]  rx_byte,
  input  logic        rx_valid,
  input  logic        rx_last,
  input  logic        rx_err,
  input  logic        rx_crc_err
);
  logic             wr_txd, wr_txc, rx_pop, rx_free;
  logic             tx_busy, tx_err, tx_ovr, tx_done;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic             rx_ready, rx_ferr, rx_fcrc;
  logic [OVF_W-1:0] ovf_cnt;
  logic [31:0]      rx_word;
  logic [1:0]       irq_en;
  logic [2:0]       rd_sel_q;
  logic             rd_pend_q;
  logic [31:0]      rd_mux;

  assign wr_txd  = reg_wen && (reg_addr == A_TXD);
  assign wr_txc  = reg_wen && (reg_addr == A_TXC);
  assign rx_free = reg_wen && (reg_addr == A_RXC) && (reg_wdata == '0);
  assign rx_pop  = reg_ren && (reg_addr == A_RXD);

  mwp_tx_engine #(.WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .wr_data(wr_txd), .wr_ctrl(wr_txc), .wdata(reg_wdata),
    .line_ready(tx_ready), .line_fail(tx_fail), .line_byte(tx_byte),
    .line_valid(tx_valid), .line_last(tx_last), .busy(tx_busy), .err(tx_err),
    .ovr(tx_ovr), .len(tx_len), .done_p(tx_done)
  );

  mwp_rx_engine #(.WORDS(BUF_WORDS), .LEN_W(LEN_W), .CNT_W(OVF_W)) u_rx (
    .clk(clk), .rst(rst), .in_byte(rx_byte), .in_valid(rx_valid), .in_last(rx_last),
    .in_err(rx_err), .in_crc(rx_crc_err), .pop(rx_pop), .free_buf(rx_free),
    .ready(rx_ready), .ferr(rx_ferr), .fcrc(rx_fcrc), .flen(rx_len),
    .ovf_cnt(ovf_cnt), .rd_word(rx_word)
  );

  always_comb begin
    rd_mux = '0;
    case (rd_sel_q)
      A_TXC: begin
        rd_mux[B_BUSY]      = tx_busy;
        rd_mux[B_TERR]      = tx_err;
        rd_mux[B_OVR]       = tx_ovr;
        rd_mux[LEN_W-1:0]   = tx_len;
      end
      A_RXD: rd_mux = rx_word;
      A_RXC: begin
        rd_mux[B_RDY]       = rx_ready;
        rd_mux[B_RERR]      = rx_ferr;
        rd_mux[B_CRC]       = rx_fcrc;
        rd_mux[LEN_W-1:0]   = rx_len;
      end
      A_IEN: rd_mux[1:0] = irq_en;
      A_OVF: rd_mux[OVF_W-1:0] = ovf_cnt;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en     <= '0;
      irq        <= 1'b0;
      rd_sel_q   <= '0;
      rd_pend_q  <= 1'b0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      if (reg_wen && (reg_addr == A_IEN)) irq_en <= reg_wdata[1:0];
      irq        <= (irq_en[IE_RX] && rx_ready) || (irq_en[IE_TX] && tx_done);
      rd_sel_q   <= reg_addr;
      rd_pend_q  <= reg_ren;
      reg_rvalid <= rd_pend_q;
      if (rd_pend_q) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/mwp_checker.sv
module mwp_checker
  import mwp_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_byte,
  input logic        tx_busy,
  input logic        tx_ovr,
  input logic        tx_done,
  input logic        irq,
  input logic [1:0]  irq_en,
  input logic        rx_ready,
  input logic        rx_free,
  input logic [15:0] rx_len,
  input logic        reg_wen,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata
);
  p_valid_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_busy);

  p_byte_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  p_done_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (!tx_busy && $past(tx_busy)));

  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_ovr && !(reg_wen && reg_addr == A_TXC && reg_wdata == 32'd0)) |=> tx_ovr);

  p_rx_held_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rx_free) |=> (rx_ready && $stable(rx_len)));

  p_rx_level_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_en[IE_RX] && rx_ready) |=> irq);

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past((irq_en[IE_RX] && rx_ready) || (irq_en[IE_TX] && tx_done)));
endmodule

bind mac_word_port mwp_checker u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
  .tx_busy(tx_busy), .tx_ovr(tx_ovr), .tx_done(tx_done), .irq(irq), .irq_en(irq_en),
  .rx_ready(rx_ready), .rx_free(rx_free), .rx_len(rx_len), .reg_wen(reg_wen),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_mac_word_port.sv
`timescale 1ns/1ps
module sim_mac_word_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0, reg_ren = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, irq;
  logic [7:0]  tx_byte;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0, tx_fail = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0, rx_err = 1'b0, rx_crc_err = 1'b0;

  int nchk = 0, nbad = 0;
  int ncap = 0, nlast = 0, lastpos = -1, irq_hi = 0;
  bit hold_ready = 1'b0;
  bit done_flag = 1'b0;
  logic [7:0] fb [0:255];
  logic [7:0] cap [0:1023];
  logic [7:0] rb [0:255];
  logic [7:0] keep [0:255];
  int unsigned seed_init;

  always #2 clk = ~clk;

  mac_word_port u0 (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_ren(reg_ren), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq(irq),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .tx_fail(tx_fail), .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_err(rx_err), .rx_crc_err(rx_crc_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  // line sink: choose ready, then record the handshake the next edge will make
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        tx_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);
        if (tx_valid && tx_ready) begin
          cap[ncap] = tx_byte;
          if (tx_last) begin nlast++; lastpos = ncap; end
          ncap++;
        end
        if (irq) irq_hi++;
      end
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_ren = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_tx_idle();
    logic [31:0] v;
    int n = 0;
    v = 32'h8000_0000;
    while (v[31] && n < 3000) begin
      bus_read(3'd1, v);
      n++;
    end
  endtask

  task automatic run_tx(input int n, input bit fail, input bit ien);
    logic [31:0] v;
    int irq0, bad;
    bus_write(3'd4, {30'd0, ien, 1'b0});
    bus_write(3'd1, 32'd0);
    for (int i = 0; i < 256; i++) fb[i] = 8'($urandom);
    for (int w = 0; w < (n + 3) / 4; w++)
      bus_write(3'd0, {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]});
    ncap = 0; nlast = 0; lastpos = -1;
    tx_fail = fail;
    irq0 = irq_hi;
    bus_write(3'd1, {1'b1, 15'd0, 16'(n)});
    wait_tx_idle();
    repeat (3) @(negedge clk);
    chk(ncap == n, "R2 byte count", 32'(ncap), 32'(n));
    bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] != fb[i]) bad++;
    chk(bad == 0, "R2 byte order", 32'(bad), 32'd0);
    chk(nlast == 1 && lastpos == n - 1, "R2 last flag", 32'(lastpos), 32'(n - 1));
    bus_read(3'd1, v);
    chk(v == {1'b0, fail, 14'd0, 16'(n)}, "R3 status after done", v, {1'b0, fail, 14'd0, 16'(n)});
    chk((irq_hi - irq0) == int'(ien), "R11 done pulse", 32'(irq_hi - irq0), 32'(ien));
    tx_fail = 1'b0;
  endtask

  task automatic send_rx(input int n, input bit e, input bit c);
    for (int i = 0; i < n; i++) rb[i] = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom % 3) begin
        @(negedge clk);
        rx_valid = 1'b0;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = rb[i]; rx_last = (i == n - 1);
      rx_err = e; rx_crc_err = c;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_err = 1'b0; rx_crc_err = 1'b0;
  endtask

  task automatic check_rx(input int n, input bit e, input bit c, input bit ien);
    logic [31:0] v, ew;
    int bad = 0;
    bus_read(3'd3, v);
    chk(v == {1'b1, e, c, 13'd0, 16'(n)}, "R6 receive status", v, {1'b1, e, c, 13'd0, 16'(n)});
    chk(irq == ien, "R10 level while held", 32'(irq), 32'(ien));
    for (int w = 0; w < (n + 3) / 4; w++) begin
      ew = '0;
      for (int k = 0; k < 4; k++) if (4*w + k < n) ew[8*k +: 8] = keep[4*w + k];
      bus_read(3'd2, v);
      if (v != ew) begin
        bad++;
        chk(1'b0, "R7 word content", v, ew);
      end
    end
    chk(bad == 0, "R7 all words", 32'(bad), 32'd0);
    bus_write(3'd3, 32'd0);
    repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R10 level drops", 32'(irq), 32'd0);
    bus_read(3'd3, v);
    chk(v == 32'd0, "R8 released", v, 32'd0);
  endtask

  task automatic rx_frame(input int n, input bit e, input bit c, input bit ien);
    bus_write(3'd4, {31'd0, ien});
    send_rx(n, e, c);
    for (int i = 0; i < n; i++) keep[i] = rb[i];
    check_rx(n, e, c, ien);
  endtask

  initial begin
    logic [31:0] v, ov;
    int n;
    seed_init = $urandom(11);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && tx_valid == 1'b0, "R10 reset outputs", {30'd0, irq, tx_valid}, 32'd0);
    bus_read(3'd1, v);
    chk(v == 32'd0, "R3 reset tx status", v, 32'd0);
    bus_read(3'd3, v);
    chk(v == 32'd0, "R6 reset rx status", v, 32'd0);

    // R12: read latency
    @(negedge clk);
    reg_ren = 1'b1; reg_addr = 3'd4;
    @(negedge clk);
    reg_ren = 1'b0;
    chk(reg_rvalid == 1'b0, "R12 not valid after one edge", 32'(reg_rvalid), 32'd0);
    @(negedge clk);
    chk(reg_rvalid == 1'b1, "R12 valid after two edges", 32'(reg_rvalid), 32'd1);

    // directed transmit lengths, R1 pointer rewind between frames
    run_tx(1, 1'b0, 1'b1);
    run_tx(4, 1'b1, 1'b1);
    run_tx(5, 1'b0, 1'b0);
    for (int r = 0; r < 6; r++) run_tx(1 + ($urandom % 64), 1'($urandom), 1'($urandom));

    // R5 overrun while stalled, then R4 clear
    bus_write(3'd4, 32'd0);
    bus_write(3'd1, 32'd0);
    for (int i = 0; i < 8; i++) fb[i] = 8'($urandom);
    bus_write(3'd0, {fb[3], fb[2], fb[1], fb[0]});
    bus_write(3'd0, {fb[7], fb[6], fb[5], fb[4]});
    hold_ready = 1'b1;
    ncap = 0; nlast = 0;
    bus_write(3'd1, {1'b1, 15'd0, 16'd8});
    repeat (5) @(negedge clk);
    bus_write(3'd0, 32'hA5A5_5A5A);
    bus_read(3'd1, v);
    chk(v == {3'b101, 13'd0, 16'd8}, "R5 overrun while busy", v, {3'b101, 13'd0, 16'd8});
    hold_ready = 1'b0;
    wait_tx_idle();
    repeat (3) @(negedge clk);
    n = 0;
    for (int i = 0; i < 8; i++) if (cap[i] != fb[i]) n++;
    chk(ncap == 8 && n == 0, "R5 frame unchanged", 32'(n), 32'd0);
    bus_read(3'd1, v);
    chk(v[29] == 1'b1, "R5 overrun sticky", v, 32'h2000_0000);
    bus_write(3'd1, 32'd0);
    bus_read(3'd1, v);
    chk(v == 32'd8, "R4 zero write clears flags", v, 32'd8);

    // receive: directed and random
    rx_frame(1, 1'b0, 1'b0, 1'b1);
    rx_frame(4, 1'b1, 1'b0, 1'b0);
    rx_frame(7, 1'b0, 1'b1, 1'b1);
    for (int r = 0; r < 6; r++) rx_frame(1 + ($urandom % 64), 1'($urandom), 1'($urandom), 1'($urandom));

    // R9 drop while held
    bus_read(3'd5, ov);
    bus_write(3'd4, 32'd1);
    send_rx(9, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) keep[i] = rb[i];
    send_rx(13, 1'b1, 1'b1);
    bus_read(3'd5, v);
    chk(v == ov + 1, "R9 drop counted", v, ov + 1);
    check_rx(9, 1'b0, 1'b0, 1'b1);
    send_rx(6, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) keep[i] = rb[i];
    check_rx(6, 1'b0, 1'b0, 1'b1);
    bus_read(3'd5, v);
    chk(v == ov + 1, "R8 next frame accepted", v, ov + 1);

    finish_run();
  end
endmodule